// File: doc/BRIEF.md
# Super I/O Configuration Port Controller

This block is the configuration front end of a multi-function I/O chip. The host reaches it through a two-byte I/O window. The lower address is an index port that points at a configuration register. The upper address is a data port that reads or writes the register the index points at. After reset the window is locked. Only a fixed four-byte key written to the index port opens it. The last key byte depends on which base port the chip answers at. While the window is open, writing the exit value to the global control register closes it again.

Registers from index 0x30 upward are banked. A global selector register chooses which logical device's bank the data port reaches. Each bank holds an activate flag, three 16-bit I/O base addresses and an IRQ number. The block drives these values straight out as per-device configuration, so the function blocks can decode their own addresses. Nine device slots exist: device numbers 0x0 to 0x7 and 0xA. Any other number reaches no bank.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the window is locked, every device is inactive, and every base address and IRQ output is zero.
- R2: Writing 0x87, 0x01, 0x55 and then K to the index port opens the window. K is 0x55 when the parameter BASE_PORT is 0x2E, and 0xAA for any other base. `cfg_unlocked` rises in the cycle after the final key write.
- R3: An index write that is not the next expected key byte sends the matcher back to its first step. If that byte is 0x87, the matcher goes to its second step instead, so 0x87,0x01,0x87,0x01,0x55,K still opens the window. A wrong last byte leaves the window locked.
- R4: While the window is locked, data-port writes change no output, and reads of either port return 0xFF.
- R5: Writing 0x02 to index 0x02 through the data port locks the window. Writing any other value to index 0x02 leaves it open. Index 0x02 reads back 0x00.
- R6: Index 0x07 holds the device selector and reads back what was written to it. Index 0x30 stores only bit 0 of the written byte as the selected device's activate flag, drives `dev_active` at the device's slot, and reads back as 0x00 or 0x01.
- R7: Indices 0x60/0x61, 0x62/0x63 and 0x64/0x65 write the high and then the low byte of base addresses 0, 1 and 2. Index 0x70 writes the IRQ. Each value reads back and appears on its output slice.
- R8: Device numbers other than 0x0–0x7 and 0xA reach no bank. Banked writes change no output, and banked reads return 0x00.
- R9: When the window is open, reading the index port returns the current index. A read of an index that has no register returns 0x00.
- R10: A banked write changes only the selected device's registers. Slot s (device s for s<8, device 0xA for slot 8) sits at bit s of `dev_active`, at bits [16s+15:16s] of each base output and at bits [8s+7:8s] of `dev_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Host write strobe, one cycle per byte |
| io_sel | input | 1 | Port select: 0 selects the index port, 1 selects the data port |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read byte for the port selected by io_sel (combinational) |
| cfg_unlocked | output | 1 | High while the configuration window is open |
| dev_active | output | NUM_DEV (9) | Activate flag per device slot |
| dev_base0 | output | NUM_DEV*16 (144) | First I/O base per slot |
| dev_base1 | output | NUM_DEV*16 (144) | Second I/O base per slot |
| dev_base2 | output | NUM_DEV*16 (144) | Third I/O base per slot |
| dev_irq | output | NUM_DEV*8 (72) | IRQ number per slot |

## Verification
The assertions check several rules on every cycle:
- the window opens only in the cycle after a completed key, and stays open until an exit write;
- a bank is written only while the window is open, and never through an unsupported device number;
- at most one bank is written at a time;
- a bank holds its value when it is not written, and its activate flag takes bit 0 of the byte written.

Only the bench's scenarios can show the rest:
- the exact key orderings, including the 0x87 restart and a wrong last byte;
- that locked writes and reads behave as stated at the ports;
- the readback values across a sweep of all 256 selector values;
- that the outputs of the other eight slots stay untouched during each bank write.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;

  localparam int NUM_DEV = 9;
  localparam int SLOT_W  = $clog2(NUM_DEV);
  localparam int NUM_BASE = 3;

  localparam logic [7:0] IDX_CTRL   = 8'h02;
  localparam logic [7:0] IDX_LDN    = 8'h07;
  localparam logic [7:0] IDX_BANKED = 8'h30;
  localparam logic [7:0] IDX_ACT    = 8'h30;
  localparam logic [7:0] IDX_BASE   = 8'h60;
  localparam logic [7:0] IDX_IRQ    = 8'h70;
  localparam logic [7:0] EXIT_VAL   = 8'h02;

  localparam logic [7:0] KEY_B0 = 8'h87;
  localparam logic [7:0] KEY_B1 = 8'h01;
  localparam logic [7:0] KEY_B2 = 8'h55;

  // Final key byte depends on the chosen base port.
  function automatic logic [7:0] key_last(input logic [7:0] base);
    return (base == 8'h2E) ? 8'h55 : 8'hAA;
  endfunction

  function automatic logic [7:0] key_byte(input logic [1:0] step, input logic [7:0] base);
    case (step)
      2'd0:    return KEY_B0;
      2'd1:    return KEY_B1;
      2'd2:    return KEY_B2;
      default: return key_last(base);
    endcase
  endfunction

  function automatic logic ldn_valid(input logic [7:0] ldn);
    return (ldn < 8'h08) || (ldn == 8'h0A);
  endfunction

  // Device number to bank slot; 0x0A occupies the last slot.
  function automatic logic [SLOT_W-1:0] ldn_slot(input logic [7:0] ldn);
    return (ldn == 8'h0A) ? SLOT_W'(NUM_DEV - 1) : ldn[SLOT_W-1:0];
  endfunction

endpackage

// File: rtl/sio_key_unlock.sv
module sio_key_unlock
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] BASE_PORT = 8'h2E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  input  logic       lock_req,
  output logic       unlocked,
  output logic       key_done
);

  logic [1:0] step_q;
  logic       key_match;

  assign key_match = idx_wr && !unlocked && (wdata == key_byte(step_q, BASE_PORT));
  assign key_done  = key_match && (step_q == 2'd3);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step_q   <= 2'd0;
      unlocked <= 1'b0;
    end else if (lock_req) begin
      unlocked <= 1'b0;
      step_q   <= 2'd0;
    end else if (key_done) begin
      unlocked <= 1'b1;
      step_q   <= 2'd0;
    end else if (idx_wr && !unlocked) begin
      if (key_match)             step_q <= step_q + 2'd1;
      else if (wdata == KEY_B0)  step_q <= 2'd1;
      else                       step_q <= 2'd0;
    end
  end

  // R2: the window opens only right after a completed key
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(key_done));

  // R5: an exit write closes the window
  a_r5_exit_locks: assert property (@(posedge clk) disable iff (!rst_n)
    lock_req |=> !unlocked);

  // R5: the window stays open until an exit write
  a_r5_hold_open: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && !lock_req) |=> unlocked);

endmodule

// File: rtl/sio_dev_bank.sv
module sio_dev_bank
  import sio_cfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  idx,
  input  logic [7:0]  wdata,
  output logic        active,
  output logic [15:0] base0,
  output logic [15:0] base1,
  output logic [15:0] base2,
  output logic [7:0]  irq,
  output logic [7:0]  rdata
);

  logic [15:0] base_q [NUM_BASE];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      irq    <= 8'h00;
      for (int k = 0; k < NUM_BASE; k++) base_q[k] <= 16'h0000;
    end else if (wr_en) begin
      if (idx == IDX_ACT) active <= wdata[0];
      if (idx == IDX_IRQ) irq    <= wdata;
      for (int k = 0; k < NUM_BASE; k++) begin
        if (idx == IDX_BASE + 8'(2*k))     base_q[k][15:8] <= wdata;
        if (idx == IDX_BASE + 8'(2*k + 1)) base_q[k][7:0]  <= wdata;
      end
    end
  end

  assign base0 = base_q[0];
  assign base1 = base_q[1];
  assign base2 = base_q[2];

  always_comb begin
    rdata = 8'h00;
    if (idx == IDX_ACT) rdata = {7'b0, active};
    if (idx == IDX_IRQ) rdata = irq;
    for (int k = 0; k < NUM_BASE; k++) begin
      if (idx == IDX_BASE + 8'(2*k))     rdata = base_q[k][15:8];
      if (idx == IDX_BASE + 8'(2*k + 1)) rdata = base_q[k][7:0];
    end
  end

  // R10: a bank that is not written keeps its contents
  a_r10_bank_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(active) && $stable(irq) && $stable(base0)
                && $stable(base1) && $stable(base2)));

  // R6: the activate flag takes bit 0 of the written byte
  a_r6_act_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && idx == IDX_ACT) |=> (active == $past(wdata[0])));

endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0] BASE_PORT = 8'h2E
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   io_wr,
  input  logic                   io_sel,
  input  logic [7:0]             io_wdata,
  output logic [7:0]             io_rdata,
  output logic                   cfg_unlocked,
  output logic [NUM_DEV-1:0]     dev_active,
  output logic [NUM_DEV*16-1:0]  dev_base0,
  output logic [NUM_DEV*16-1:0]  dev_base1,
  output logic [NUM_DEV*16-1:0]  dev_base2,
  output logic [NUM_DEV*8-1:0]   dev_irq
);

  logic [7:0]         idx_q;
  logic [7:0]         ldn_q;
  logic               idx_wr;
  logic               dat_wr;
  logic               lock_req;
  logic               key_done;
  logic               sel_valid;
  logic [SLOT_W-1:0]  sel_slot;
  logic [NUM_DEV-1:0] bank_wr;
  logic [7:0]         bank_rd [NUM_DEV];
  logic [7:0]         sel_rd;

  assign idx_wr    = io_wr && !io_sel;
  assign dat_wr    = io_wr && io_sel && cfg_unlocked;
  assign lock_req  = dat_wr && (idx_q == IDX_CTRL) && (io_wdata == EXIT_VAL);
  assign sel_valid = ldn_valid(ldn_q);
  assign sel_slot  = ldn_slot(ldn_q);

  sio_key_unlock #(.BASE_PORT(BASE_PORT)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .wdata    (io_wdata),
    .lock_req (lock_req),
    .unlocked (cfg_unlocked),
    .key_done (key_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q <= 8'h00;
      ldn_q <= 8'h00;
    end else begin
      if (idx_wr && cfg_unlocked) idx_q <= io_wdata;
      if (dat_wr && idx_q == IDX_LDN) ldn_q <= io_wdata;
    end
  end

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_bank
    assign bank_wr[g] = dat_wr && (idx_q >= IDX_BANKED) && sel_valid
                        && (sel_slot == SLOT_W'(g));
    sio_dev_bank u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_wr[g]),
      .idx    (idx_q),
      .wdata  (io_wdata),
      .active (dev_active[g]),
      .base0  (dev_base0[g*16 +: 16]),
      .base1  (dev_base1[g*16 +: 16]),
      .base2  (dev_base2[g*16 +: 16]),
      .irq    (dev_irq[g*8 +: 8]),
      .rdata  (bank_rd[g])
    );
  end

  always_comb begin
    sel_rd = 8'h00;
    for (int g = 0; g < NUM_DEV; g++)
      if (sel_valid && sel_slot == SLOT_W'(g)) sel_rd = bank_rd[g];
  end

  always_comb begin
    if (!cfg_unlocked)          io_rdata = 8'hFF;
    else if (!io_sel)           io_rdata = idx_q;
    else if (idx_q == IDX_LDN)  io_rdata = ldn_q;
    else if (idx_q >= IDX_BANKED) io_rdata = sel_rd;
    else                        io_rdata = 8'h00;
  end

  // R4: banks are written only while the window is open
  a_r4_write_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    (|bank_wr) |-> cfg_unlocked);

  // R10: at most one bank takes a write
  a_r10_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_wr));

  // R8: an unsupported device number reaches no bank
  a_r8_invalid_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_valid |-> (bank_wr == '0));

  // R2: index writes while locked never move the index register
  a_r2_locked_index_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_unlocked && !key_done) |=> $stable(idx_q));

endmodule

// File: tb/sio_cfg_port_bench.sv
module sio_cfg_port_bench;
  import sio_cfg_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic io_wr = 1'b0;
  logic io_sel = 1'b0;
  logic [7:0] io_wdata = 8'h00;
  logic [7:0] io_rdata;
  logic cfg_unlocked;
  logic [NUM_DEV-1:0] dev_active;
  logic [NUM_DEV*16-1:0] dev_base0, dev_base1, dev_base2;
  logic [NUM_DEV*8-1:0] dev_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_cfg_port u_sio_cfg_port (
    .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_sel(io_sel),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_unlocked(cfg_unlocked),
    .dev_active(dev_active), .dev_base0(dev_base0), .dev_base1(dev_base1),
    .dev_base2(dev_base2), .dev_irq(dev_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    io_wr = 1'b1; io_sel = sel; io_wdata = d;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] idx, output logic [7:0] v);
    wr(1'b0, idx);
    io_sel = 1'b1;
    #1 v = io_rdata;
  endtask

  task automatic wr_reg(input logic [7:0] idx, input logic [7:0] d);
    wr(1'b0, idx);
    wr(1'b1, d);
  endtask

  task automatic send_key(input logic [7:0] last);
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, last);
  endtask

  // Pattern values computed per slot, written and then expected back.
  function automatic logic [15:0] pat_base(input int s, input int k);
    return 16'((s + 1) * 16'h0111 + k * 16'h1020);
  endfunction
  function automatic logic [7:0] pat_irq(input int s);
    return 8'(s * 5 + 3);
  endfunction
  function automatic logic pat_act(input int s);
    return (s % 2) == 0;
  endfunction
  function automatic logic [7:0] slot_ldn(input int s);
    return (s < 8) ? 8'(s) : 8'h0A;
  endfunction

  task automatic check_slot(input int s, input bit written, input string req);
    chk(req, 32'(dev_active[s]), written ? 32'(pat_act(s)) : 0);
    chk(req, 32'(dev_base0[s*16 +: 16]), written ? 32'(pat_base(s,0)) : 0);
    chk(req, 32'(dev_base1[s*16 +: 16]), written ? 32'(pat_base(s,1)) : 0);
    chk(req, 32'(dev_base2[s*16 +: 16]), written ? 32'(pat_base(s,2)) : 0);
    chk(req, 32'(dev_irq[s*8 +: 8]),     written ? 32'(pat_irq(s))    : 0);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 locked", 32'(cfg_unlocked), 0);
    chk("R1 active", 32'(dev_active), 0);
    chk("R1 base0", 32'(|dev_base0), 0);
    chk("R1 irq", 32'(|dev_irq), 0);

    // R4: locked window ignores data writes, reads 0xFF
    wr(1'b1, 8'h01);
    io_sel = 1'b1; #1 chk("R4 data read locked", 32'(io_rdata), 32'hFF);
    io_sel = 1'b0; #1 chk("R4 index read locked", 32'(io_rdata), 32'hFF);
    chk("R4 no output change", 32'(dev_active), 0);

    // R3: wrong last byte (0xAA with base 0x2E) leaves it locked
    send_key(8'hAA);
    chk("R3 wrong last byte", 32'(cfg_unlocked), 0);
    // R3: a mismatch resets the matcher
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h12);
    wr(1'b0, 8'h01); wr(1'b0, 8'h55); wr(1'b0, 8'h55);
    chk("R3 mismatch resets", 32'(cfg_unlocked), 0);
    // R3: 0x87 mid-sequence restarts at step two
    wr(1'b0, 8'h87); wr(1'b0, 8'h01); wr(1'b0, 8'h87);
    wr(1'b0, 8'h01); wr(1'b0, 8'h55);
    chk("R2 not open before last byte", 32'(cfg_unlocked), 0);
    wr(1'b0, 8'h55);
    chk("R3 restart on 0x87 opens", 32'(cfg_unlocked), 1);

    // R5: other values at index 0x02 keep it open; 0x02 closes it
    wr_reg(IDX_CTRL, 8'h01);
    chk("R5 non-exit keeps open", 32'(cfg_unlocked), 1);
    rd_reg(IDX_CTRL, v);
    chk("R5 ctrl reads zero", 32'(v), 0);
    wr_reg(IDX_CTRL, EXIT_VAL);
    chk("R5 exit locks", 32'(cfg_unlocked), 0);

    // R2: plain key opens again
    send_key(8'h55);
    chk("R2 key opens", 32'(cfg_unlocked), 1);

    // R9: index readback, unimplemented index
    wr(1'b0, 8'h21);
    io_sel = 1'b0; #1 chk("R9 index readback", 32'(io_rdata), 32'h21);
    io_sel = 1'b1; #1 chk("R9 unimplemented zero", 32'(io_rdata), 0);

    // R6/R7/R10: program each slot in turn, checking the others stay put
    for (int s = 0; s < NUM_DEV; s++) begin
      wr_reg(IDX_LDN, slot_ldn(s));
      rd_reg(IDX_LDN, v);
      chk("R6 selector readback", 32'(v), 32'(slot_ldn(s)));
      wr_reg(IDX_ACT, pat_act(s) ? 8'hA1 : 8'hA0);
      for (int k = 0; k < NUM_BASE; k++) begin
        wr_reg(IDX_BASE + 8'(2*k),     pat_base(s,k)[15:8]);
        wr_reg(IDX_BASE + 8'(2*k + 1), pat_base(s,k)[7:0]);
      end
      wr_reg(IDX_IRQ, pat_irq(s));
      for (int t = 0; t < NUM_DEV; t++)
        check_slot(t, t <= s, (t == s) ? "R7 slot outputs" : "R10 other slots");
      rd_reg(IDX_ACT, v);
      chk("R6 act readback bit0", 32'(v), 32'(pat_act(s)));
      rd_reg(IDX_BASE + 8'd3, v);
      chk("R7 base1 low readback", 32'(v), 32'(pat_base(s,1)[7:0]));
      rd_reg(IDX_IRQ, v);
      chk("R7 irq readback", 32'(v), 32'(pat_irq(s)));
    end

    // R8: every unsupported device number reaches no bank
    for (int n = 0; n < 256; n++) begin
      if (ldn_valid(8'(n))) continue;
      wr_reg(IDX_LDN, 8'(n));
      wr_reg(IDX_ACT, 8'hFF);
      wr_reg(IDX_IRQ, 8'hEE);
      rd_reg(IDX_IRQ, v);
      chk("R8 invalid reads zero", 32'(v), 0);
    end
    for (int t = 0; t < NUM_DEV; t++) check_slot(t, 1, "R8 outputs unchanged");

    // R4: after locking, data writes leave the banks alone
    wr_reg(IDX_LDN, 8'h01);
    wr(1'b0, IDX_ACT);
    wr_reg(IDX_CTRL, EXIT_VAL);
    wr(1'b1, 8'h00);
    chk("R4 locked write ignored", 32'(dev_active[1]), 32'(pat_act(1)));

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule